// File: doc/BRIEF.md
# Snoop-Aware Address Bus Arbiter

This block decides which of several bus masters may drive the shared address bus. Each master has its own active-low request line and receives its own active-low grant line. The arbiter also watches three shared active-low bus strobes: transfer start, address acknowledge and address retry. It uses them to follow each address tenure from grant to completion. Under normal conditions, requesters are served one at a time in round-robin order.

A retry is qualified when it is asserted in the cycle directly after the address acknowledge. In the cycle after a qualified retry, the only master allowed to request is the snooper that must copy modified data back to memory, and the arbiter gives the bus to that master ahead of the retried one. The grant stays parked on that master for as long as it keeps requesting without starting its tenure, so a slow snooper does not lose its turn. Once the snooper starts its push, no other master receives a grant until a push-done pulse arrives. A parameter selects either a registered grant or a combinational grant; the combinational grant appears one cycle earlier.

The controller is a single state machine with these states: IDLE, GRANT, TENURE, POST_ACK, SNOOP_WIN, SNOOP_HOLD and PUSH. Its transitions are:
- IDLE→GRANT when any request is present.
- GRANT→TENURE on a transfer start.
- GRANT→IDLE when the requester withdraws.
- TENURE→POST_ACK on an acknowledge.
- POST_ACK→SNOOP_WIN on a retry.
- POST_ACK→IDLE when there is no retry.
- SNOOP_WIN→SNOOP_HOLD when a request is present.
- SNOOP_WIN→IDLE when no request is present.
- SNOOP_HOLD→PUSH on a transfer start.
- SNOOP_HOLD→IDLE when the snooper withdraws.
- PUSH→IDLE on push-done.

Top module: `snoop_addr_arbiter`

## Requirements
- R1: While reset is active, every grant is high (inactive), even if masters are requesting. After reset, no grant is given until some request goes low.
- R2: At no time is more than one grant line low.
- R3: Normal grants rotate round-robin. The search starts at the master after the most recently granted one and wraps from the highest index to index 0. After reset, the search starts at master 0.
- R4: A normal grant is removed once a transfer start is seen. It is also removed if the granted master withdraws its request before starting. From that transfer start until the cycle after the acknowledge, no grant is given.
- R5: A retry is qualified when it is low in the cycle directly after an acknowledge. In the next cycle, the requesting master receives the grant, whatever the round-robin position. If several masters request in that cycle, the lowest index wins.
- R6: A retry at any other time has no effect on arbitration. This includes a retry during the tenure before the acknowledge and a retry during a push.
- R7: A grant given after a qualified retry stays on that master for as long as its request stays low and no transfer start is seen. Requests from other masters are ignored during this time.
- R8: If the snooper withdraws its request before starting, its grant is removed and normal arbitration resumes.
- R9: After the snooper's transfer start, no grant is given until push-done is pulsed high. Arbitration resumes in the next cycle.
- R10: With COMB_GRANT=1, each grant change appears in the same cycle as the inputs that cause it. This is one cycle earlier than with COMB_GRANT=0, where the change appears after the next clock edge.
- R11: If no master requests in the cycle after a qualified retry, the arbiter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_n | input | N | Per-master bus request, active low |
| ts_n | input | 1 | Shared transfer start, active low |
| aack_n | input | 1 | Shared address acknowledge, active low |
| artry_n | input | 1 | Shared address retry, active low |
| push_done | input | 1 | High for one cycle when the snoop copy-back push completes |
| bg_n | output | N | Per-master bus grant, active low |

## Verification
The bench targets the following corner cases:

- **Retry timing.** It places a retry both before the acknowledge and during a push. A design that treats any retry as qualified would give snooper priority at the wrong time.
- **Parked snooper grant.** It holds a snooper's grant while another master requests. A design that re-arbitrates would move the grant away from the snooper.
- **Push lockout.** It drives other requests during a push. A leaky lockout would grant before push-done.
- **Snooper withdrawal and empty retry cycle.** It covers a snooper that withdraws and a retry with no requester. A design that gets these wrong would leave the bus parked or stuck.
- **Round-robin wrap and grant timing.** It checks wrap-around of the round-robin pointer and compares the registered and combinational grant variants cycle by cycle.

// File: rtl/abr_pkg.sv
package abr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT,
        ST_TENURE,
        ST_POST_ACK,
        ST_SNOOP_WIN,
        ST_SNOOP_HOLD,
        ST_PUSH
    } abr_state_e;

    function automatic logic grant_state(abr_state_e st);
        return (st == ST_GRANT) || (st == ST_SNOOP_HOLD);
    endfunction

endpackage

// File: rtl/abr_pick.sv
// First active requester found when searching upward from start_idx, wrapping.
module abr_pick #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start_idx,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && req[(int'(start_idx) + i) % N]) begin
                found = 1'b1;
                idx   = IW'((int'(start_idx) + i) % N);
            end
        end
    end

endmodule

// File: rtl/abr_grant_dec.sv
// Owner index to one-hot active-high grant vector.
module abr_grant_dec #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          en,
    input  logic [IW-1:0] owner,
    output logic [N-1:0]  gnt
);

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign gnt[g] = en && (owner == IW'(g));
    end

endmodule

// File: rtl/snoop_addr_arbiter.sv
module snoop_addr_arbiter
    import abr_pkg::*;
#(
    parameter int N          = 4,
    parameter bit COMB_GRANT = 1'b0,
    localparam int IW        = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] br_n,
    input  logic         ts_n,
    input  logic         aack_n,
    input  logic         artry_n,
    input  logic         push_done,
    output logic [N-1:0] bg_n
);

    abr_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] ptr_q, ptr_d;

    logic [N-1:0]  req;
    logic          rr_found, lo_found;
    logic [IW-1:0] rr_idx, lo_idx;
    logic [N-1:0]  gnt;

    assign req = ~br_n;

    abr_pick #(.N(N)) u_rr_pick (
        .req       (req),
        .start_idx (ptr_q),
        .found     (rr_found),
        .idx       (rr_idx)
    );

    abr_pick #(.N(N)) u_lo_pick (
        .req       (req),
        .start_idx ('0),
        .found     (lo_found),
        .idx       (lo_idx)
    );

    function automatic logic [IW-1:0] after(logic [IW-1:0] i);
        return (i == IW'(N - 1)) ? '0 : i + 1'b1;
    endfunction

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rr_found) begin
                    state_d = ST_GRANT;
                    owner_d = rr_idx;
                    ptr_d   = after(rr_idx);
                end
            end
            ST_GRANT: begin
                if (!ts_n)                state_d = ST_TENURE;
                else if (br_n[owner_q])   state_d = ST_IDLE;
            end
            ST_TENURE: begin
                if (!aack_n)              state_d = ST_POST_ACK;
            end
            ST_POST_ACK: begin
                state_d = !artry_n ? ST_SNOOP_WIN : ST_IDLE;
            end
            ST_SNOOP_WIN: begin
                if (lo_found) begin
                    state_d = ST_SNOOP_HOLD;
                    owner_d = lo_idx;
                    ptr_d   = after(lo_idx);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SNOOP_HOLD: begin
                if (!ts_n)                state_d = ST_PUSH;
                else if (br_n[owner_q])   state_d = ST_IDLE;
            end
            ST_PUSH: begin
                if (push_done)            state_d = ST_IDLE;
            end
            default:                      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // Grant decode: registered view or look-ahead view, picked by parameter
    abr_grant_dec #(.N(N)) u_grant_dec (
        .en    (COMB_GRANT ? grant_state(state_d) : grant_state(state_q)),
        .owner (COMB_GRANT ? owner_d : owner_q),
        .gnt   (gnt)
    );

    // Outputs
    always_comb begin
        bg_n = '1;
        if (rst_n) bg_n = ~gnt;
    end

endmodule

// File: rtl/snoop_addr_arbiter_chk.sv
module snoop_addr_arbiter_chk
    import abr_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  br_n,
    input logic          ts_n,
    input logic          push_done,
    input logic [N-1:0]  bg_n,
    input abr_state_e    state_q,
    input logic [IW-1:0] owner_q
);

    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bg_n) <= 1);

    a_r4_tenure_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TENURE) |-> (&bg_n));

    a_r5_snooper_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SNOOP_WIN && !(&br_n)) |=> (state_q == ST_SNOOP_HOLD));

    a_r7_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SNOOP_HOLD && !br_n[owner_q] && ts_n)
        |=> (state_q == ST_SNOOP_HOLD && $stable(owner_q)));

    a_r9_push_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH) |-> (&bg_n));

    a_r9_push_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH && push_done) |=> (state_q == ST_IDLE));

    a_r11_empty_win: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SNOOP_WIN && (&br_n)) |=> (state_q == ST_IDLE));

endmodule

bind snoop_addr_arbiter snoop_addr_arbiter_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_n      (br_n),
    .ts_n      (ts_n),
    .push_done (push_done),
    .bg_n      (bg_n),
    .state_q   (state_q),
    .owner_q   (owner_q)
);

// File: tb/snoop_addr_arbiter_bench.sv
module snoop_addr_arbiter_bench;

    localparam int N     = 4;
    localparam int NVEC  = 41;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] br_n = '1;
    logic         ts_n = 1'b1, aack_n = 1'b1, artry_n = 1'b1, push_done = 1'b0;
    logic [N-1:0] bg_reg_n, bg_comb_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    snoop_addr_arbiter #(.N(N), .COMB_GRANT(1'b0)) u_snoop_addr_arbiter (
        .clk(clk), .rst_n(rst_n), .br_n(br_n), .ts_n(ts_n), .aack_n(aack_n),
        .artry_n(artry_n), .push_done(push_done), .bg_n(bg_reg_n)
    );

    snoop_addr_arbiter #(.N(N), .COMB_GRANT(1'b1)) u_snoop_addr_arbiter_comb (
        .clk(clk), .rst_n(rst_n), .br_n(br_n), .ts_n(ts_n), .aack_n(aack_n),
        .artry_n(artry_n), .push_done(push_done), .bg_n(bg_comb_n)
    );

    // {request[3:0], ts, aack, artry, push_done, expected grant[3:0]}, all active high
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0000_0000_0000, // 0
        12'b0011_0000_0001, // 1
        12'b0011_1000_0000, // 2
        12'b0010_0000_0000, // 3
        12'b0010_0100_0000, // 4
        12'b0010_0000_0000, // 5
        12'b0010_0000_0010, // 6
        12'b0010_1000_0000, // 7
        12'b1001_0100_0000, // 8
        12'b1001_0000_0000, // 9
        12'b1001_0000_1000, // 10
        12'b1001_1000_0000, // 11
        12'b0001_0100_0000, // 12
        12'b0001_0010_0000, // 13
        12'b0100_0000_0100, // 14
        12'b0101_0000_0100, // 15
        12'b0101_0000_0100, // 16
        12'b0101_1000_0000, // 17
        12'b0001_0100_0000, // 18
        12'b0001_0010_0000, // 19
        12'b0001_0001_0000, // 20
        12'b0001_0000_0001, // 21
        12'b0001_1000_0000, // 22
        12'b0000_0100_0000, // 23
        12'b0000_0010_0000, // 24
        12'b0000_0000_0000, // 25
        12'b0010_0000_0010, // 26
        12'b0010_1000_0000, // 27
        12'b0000_0100_0000, // 28
        12'b0000_0010_0000, // 29
        12'b0001_0000_0001, // 30
        12'b0100_0000_0000, // 31
        12'b0100_0000_0100, // 32
        12'b0000_0000_0000, // 33
        12'b0000_0000_0000, // 34
        12'b0001_0000_0001, // 35
        12'b0001_1000_0000, // 36
        12'b0010_0010_0000, // 37
        12'b0010_0100_0000, // 38
        12'b0010_0000_0000, // 39
        12'b0010_0000_0010  // 40
    };

    function automatic string vec_tag(int i);
        if (i == 0)                        return "R1";
        if (i == 1 || i == 6 || i == 10)   return "R3";
        if (i == 21)                       return "R3/R9";
        if (i == 19)                       return "R6";
        if (i >= 13 && i <= 14)            return "R5";
        if (i >= 15 && i <= 16)            return "R7";
        if (i >= 17 && i <= 20)            return "R9";
        if (i >= 22 && i <= 24)            return "R5";
        if (i == 25)                       return "R11";
        if (i >= 26 && i <= 30)            return "R5";
        if (i >= 31 && i <= 32)            return "R8";
        if (i >= 35)                       return "R6";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_one_hot(input logic [N-1:0] bgn);
        n_checks++;
        if ($countones(~bgn) > 1) begin
            n_fail++;
            $display("FAIL R2 actual=%b expected=at most one low", bgn);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        // R1: requests present during reset produce no grant
        br_n = '0;
        repeat (3) @(negedge clk);
        check("R1", ~bg_reg_n, '0);
        check("R1", ~bg_comb_n, '0);
        br_n = '1;
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R1", ~bg_reg_n, '0);
        end

        // Vector table: comb grant in the same cycle (R10), registered one edge later
        for (int i = 0; i < NVEC; i++) begin
            br_n      = ~VEC[i][11:8];
            ts_n      = ~VEC[i][7];
            aack_n    = ~VEC[i][6];
            artry_n   = ~VEC[i][5];
            push_done =  VEC[i][4];
            #1;
            check("R10", ~bg_comb_n, VEC[i][3:0]);
            check_one_hot(bg_comb_n);
            @(negedge clk);
            check(vec_tag(i), ~bg_reg_n, VEC[i][3:0]);
            check_one_hot(bg_reg_n);
        end

        // R1: reset in the middle of a grant drops it at once
        br_n = 4'b1101; ts_n = 1'b1; aack_n = 1'b1; artry_n = 1'b1; push_done = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", ~bg_reg_n, '0);
        check("R1", ~bg_comb_n, '0);
        @(negedge clk);
        br_n = '1;
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R1", ~bg_reg_n, '0);
        end
        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule